// File: doc/BRIEF.md
# E1 Timeslot-Zero Transmit Formatter

This block produces the timeslot-zero byte for every frame of an outgoing E1 (PCM 30) stream. It counts frames through the 16-frame CRC-4 multiframe. In even frames it emits the frame alignment word, with the CRC-4 check bit in the top position. In odd frames it emits the non-alignment word. That word carries a fixed one, the remote alarm and five national (Sa) bits. Its leading bit holds the multiframe alignment pattern in the first six odd frames and the two far-end error bits in the last two.

The Sa bits come from a five-byte transmit buffer. Each byte serves one Sa position, and each of its eight bits serves one odd frame. A serial data-link bit can take the place of the buffer value in one selected Sa position. An active-low transmit-AIS input forces the byte to all ones from power-up, whatever the other inputs hold.

The surrounding framer pulses a frame strobe once per frame and a multiframe-start input to realign the count. It supplies the four C bits and the two E bits from its own CRC-4 logic. It reads the byte combinationally for the current frame.

Top module: `e1_ts0_formatter`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the frame number is 0 and, with transmit-AIS released, the byte is the frame-0 alignment word.
- R2: In every even frame, byte bits [6:0] equal 7'b0011011; byte bit 7 is bit 1 of the word, the most significant bit.
- R3: Byte bit 7 of even frame f carries crc_bits[(f/2) mod 4], where crc_bits[0] is C1 and crc_bits[3] is C4.
- R4: In every odd frame, bit [6] is 1 and bit [5] equals rai. Bits [4:0] are Sa4, Sa5, Sa6, Sa7, Sa8, from bit 4 down to bit 0.
- R5: Byte bit 7 of odd frames 1, 3, 5, 7, 9 and 11 is 0, 0, 1, 0, 1, 1 respectively.
- R6: Byte bit 7 of odd frame 13 is e_bits[0] (E1), and of odd frame 15 is e_bits[1] (E2).
- R7: The Sa(4+i) bit of odd frame 2k+1 is bit (7-k) of nat_buf[8*i+7 : 8*i], for i = 0..4 and k = 0..7; the buffer's bit 7 serves frame 1.
- R8: While dl_en is 1 and dl_sel is i (0..4), dl_bit replaces the Sa(4+i) buffer bit. The other Sa positions and all even frames are unchanged. A dl_sel value of 5..7 overrides nothing.
- R9: While ais_n is 0 the byte is 8'hFF, including during reset.
- R10: A frame_stb at a clock edge advances the frame number by one, from 15 back to 0. Without frame_stb or mf_start the frame number holds.
- R11: An mf_start at a clock edge sets the frame number to 0, taking priority over frame_stb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse: advance to the next frame |
| mf_start | input | 1 | One-cycle pulse: next frame is frame 0 |
| crc_bits | input | 4 | C1..C4 (bit 0 is C1) |
| e_bits | input | 2 | E1 (bit 0) and E2 (bit 1) |
| rai | input | 1 | Remote alarm bit for odd frames |
| nat_buf | input | 40 | Five national-bit bytes; byte i carries Sa(4+i) |
| dl_en | input | 1 | Data-link override enable |
| dl_sel | input | 3 | Sa position replaced by the data link (0 = Sa4 .. 4 = Sa8) |
| dl_bit | input | 1 | Data-link bit |
| ais_n | input | 1 | Active-low transmit AIS: low forces all ones |
| ts0_byte | output | 8 | Timeslot-zero byte of the current frame, bit 7 sent first |
| frame_num | output | 4 | Current frame in the multiframe |

## Verification
The bench uses the default parameters: a 16-frame multiframe and five Sa positions, so the buffer is five bytes of eight columns. At these values one walk of the vector table covers every frame position. That walk covers every C-bit slot, every alignment-pattern slot, both error-bit slots and every buffer column. The three-bit select also leaves the values 5..7 free, so the bench can check that those values disable the data-link override.

// File: rtl/e1_ts0_pkg.sv
// Package: constants and the odd-frame word layout shared by the
// timeslot-zero formatter. Assumes the standard 16-frame CRC-4 multiframe.
package e1_ts0_pkg;
    localparam int          CRC_SLOTS = 4;
    localparam logic [6:0]  FAS_TAIL  = 7'b0011011;

    // Layout of the odd-frame (non-alignment) word, MSB is sent first.
    typedef struct packed {
        logic       lead;      // multiframe pattern or E bit
        logic       fixed_one; // always 1
        logic       alarm;     // remote alarm
        logic [4:0] sa;        // Sa4 (bit 4) .. Sa8 (bit 0)
    } nfas_word_t;

    // Multiframe alignment pattern for odd-frame column k (0..5).
    function automatic logic mfas_bit(input logic [2:0] k);
        case (k)
            3'd2, 3'd4, 3'd5: mfas_bit = 1'b1;
            default:          mfas_bit = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/e1_frame_seq.sv
// Frame sequencer: counts frames within the multiframe.
// Assumes frame_stb and mf_start are single-cycle pulses in the clk domain;
// mf_start wins over frame_stb.
module e1_frame_seq #(
    parameter int FRAMES = 16,
    localparam int FW    = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          mf_start,
    output logic [FW-1:0] frame_num
);
    localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

    // Purpose: hold, advance, wrap or realign the frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_num <= '0;
        end else if (mf_start) begin
            frame_num <= '0;
        end else if (frame_stb) begin
            frame_num <= (frame_num == LAST) ? '0 : frame_num + FW'(1);
        end
    end

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !mf_start && frame_num == LAST) |=> frame_num == '0); // R10
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !mf_start && frame_num != LAST) |=> frame_num == $past(frame_num) + FW'(1)); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && !mf_start) |=> $stable(frame_num)); // R10
    AST_MF_START: assert property (@(posedge clk) disable iff (!rst_n)
        mf_start |=> frame_num == '0); // R11
endmodule

// File: rtl/e1_sa_select.sv
// Sa bit selector: picks the buffer column for the current odd frame and
// applies the optional data-link override to one Sa position.
// Assumes byte i of nat_buf feeds Sa(4+i) and bit COLS-1 feeds column 0.
module e1_sa_select #(
    parameter int SA_COUNT = 5,
    parameter int COLS     = 8,
    localparam int CW      = $clog2(COLS),
    localparam int SW      = $clog2(SA_COUNT)
) (
    input  logic [CW-1:0]          col,
    input  logic [SA_COUNT*COLS-1:0] nat_buf,
    input  logic                   dl_en,
    input  logic [SW-1:0]          dl_sel,
    input  logic                   dl_bit,
    output logic [SA_COUNT-1:0]    sa
);
    logic [CW-1:0] rev_col;
    assign rev_col = CW'(COLS - 1) - col;

    for (genvar i = 0; i < SA_COUNT; i++) begin : g_sa
        logic [COLS-1:0] row;
        logic            take_dl;
        assign row     = nat_buf[i*COLS +: COLS];
        assign take_dl = dl_en && (dl_sel == SW'(i));
        // Purpose: choose buffer column bit or data-link bit for Sa(4+i).
        always_comb begin
            sa[SA_COUNT-1-i] = take_dl ? dl_bit : row[rev_col];
        end
    end
endmodule

// File: rtl/e1_ts0_assemble.sv
// Word assembler: forms the alignment or non-alignment word from the frame
// number and applies the all-ones AIS override. Assumes 16 frames, 4 C bits.
module e1_ts0_assemble
    import e1_ts0_pkg::*;
#(
    parameter int FW = 4,
    localparam int CW = FW - 1
) (
    input  logic [FW-1:0] frame_num,
    input  logic [CRC_SLOTS-1:0] crc_bits,
    input  logic [1:0]    e_bits,
    input  logic          rai,
    input  logic [4:0]    sa,
    input  logic          ais_n,
    output logic [7:0]    ts0_byte
);
    logic [CW-1:0] col;
    logic          lead_odd;
    nfas_word_t    nfas;
    logic [7:0]    fas;

    assign col = frame_num[FW-1:1];

    // Purpose: leading bit of the odd word, pattern then E1/E2.
    always_comb begin
        if (col == CW'(6))      lead_odd = e_bits[0];
        else if (col == CW'(7)) lead_odd = e_bits[1];
        else                    lead_odd = mfas_bit(3'(col));
    end

    // Purpose: build both candidate words.
    always_comb begin
        fas            = {crc_bits[col[1:0]], FAS_TAIL};
        nfas.lead      = lead_odd;
        nfas.fixed_one = 1'b1;
        nfas.alarm     = rai;
        nfas.sa        = sa;
    end

    // Purpose: select by frame parity and apply AIS.
    always_comb begin
        if (!ais_n)            ts0_byte = 8'hFF;
        else if (frame_num[0]) ts0_byte = nfas;
        else                   ts0_byte = fas;
    end
endmodule

// File: rtl/e1_ts0_formatter.sv
// Top: E1 timeslot-zero transmit formatter. Counts frames of the CRC-4
// multiframe and presents the timeslot-zero byte combinationally.
// Assumes pulses are synchronous to clk; reset is synchronous active-low.
module e1_ts0_formatter #(
    parameter int FRAMES_PER_MF = 16,
    parameter int SA_COUNT      = 5,
    localparam int COLS         = FRAMES_PER_MF / 2,
    localparam int FW           = $clog2(FRAMES_PER_MF),
    localparam int CW           = FW - 1,
    localparam int SW           = $clog2(SA_COUNT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_stb,
    input  logic                     mf_start,
    input  logic [3:0]               crc_bits,
    input  logic [1:0]               e_bits,
    input  logic                     rai,
    input  logic [SA_COUNT*COLS-1:0] nat_buf,
    input  logic                     dl_en,
    input  logic [SW-1:0]            dl_sel,
    input  logic                     dl_bit,
    input  logic                     ais_n,
    output logic [7:0]               ts0_byte,
    output logic [FW-1:0]            frame_num
);
    logic [SA_COUNT-1:0] sa;

    e1_frame_seq #(.FRAMES(FRAMES_PER_MF)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .mf_start  (mf_start),
        .frame_num (frame_num)
    );

    e1_sa_select #(.SA_COUNT(SA_COUNT), .COLS(COLS)) u_sa (
        .col     (frame_num[FW-1:1]),
        .nat_buf (nat_buf),
        .dl_en   (dl_en),
        .dl_sel  (dl_sel),
        .dl_bit  (dl_bit),
        .sa      (sa)
    );

    e1_ts0_assemble #(.FW(FW)) u_asm (
        .frame_num (frame_num),
        .crc_bits  (crc_bits),
        .e_bits    (e_bits),
        .rai       (rai),
        .sa        (sa),
        .ais_n     (ais_n),
        .ts0_byte  (ts0_byte)
    );

    AST_AIS_ONES: assert property (@(posedge clk)
        !ais_n |-> ts0_byte == 8'hFF); // R9
    AST_EVEN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (ais_n && !frame_num[0]) |-> ts0_byte[6:0] == 7'b0011011); // R2
    AST_ODD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (ais_n && frame_num[0]) |-> (ts0_byte[6] && ts0_byte[5] == rai)); // R4
    AST_RESET_FRAME: assert property (@(posedge clk)
        !rst_n |=> frame_num == '0); // R1
endmodule

// File: tb/e1_ts0_formatter_tb.sv
`timescale 1ns/1ps
module e1_ts0_formatter_tb;
    logic        clk = 1'b0;
    logic        rst_n, frame_stb, mf_start, rai, dl_en, dl_bit, ais_n;
    logic [3:0]  crc_bits;
    logic [1:0]  e_bits;
    logic [39:0] nat_buf;
    logic [2:0]  dl_sel;
    logic [7:0]  ts0_byte;
    logic [3:0]  frame_num;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    e1_ts0_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mf_start(mf_start),
        .crc_bits(crc_bits), .e_bits(e_bits), .rai(rai), .nat_buf(nat_buf),
        .dl_en(dl_en), .dl_sel(dl_sel), .dl_bit(dl_bit), .ais_n(ais_n),
        .ts0_byte(ts0_byte), .frame_num(frame_num)
    );

    // Expected bytes for frames 0..15 with the baseline stimulus:
    // bytes Sa4..Sa8 = A5 3C F0 0F 96, C1..C4 = 1,0,1,0, E1=0, E2=1, rai=1.
    localparam logic [7:0] EXP [16] = '{
        8'h9B, 8'h75, 8'h1B, 8'h64, 8'h9B, 8'hFC, 8'h1B, 8'h6D,
        8'h9B, 8'hEA, 8'h1B, 8'hFB, 8'h9B, 8'h63, 8'h1B, 8'hF2
    };

    task automatic chk(input logic [7:0] exp_b, input logic [3:0] exp_f, input string req);
        checks++;
        if (ts0_byte !== exp_b || frame_num !== exp_f) begin
            failures++;
            $display("FAIL %s: byte=%h frame=%0d expected byte=%h frame=%0d",
                     req, ts0_byte, frame_num, exp_b, exp_f);
        end
    endtask

    // Pulse frame_stb (and optionally mf_start) across one rising edge.
    task automatic step(input logic stb, input logic mfs);
        @(negedge clk);
        frame_stb = stb;
        mf_start  = mfs;
        @(posedge clk);
        #1;
        frame_stb = 1'b0;
        mf_start  = 1'b0;
    endtask

    task automatic go_frame(input int f);
        step(1'b0, 1'b1);
        for (int i = 0; i < f; i++) step(1'b1, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; frame_stb = 1'b0; mf_start = 1'b0; rai = 1'b1;
        dl_en = 1'b0; dl_bit = 1'b0; dl_sel = 3'd0; ais_n = 1'b0;
        crc_bits = 4'b0101; e_bits = 2'b10;
        nat_buf = {8'h96, 8'h0F, 8'hF0, 8'h3C, 8'hA5};
        repeat (3) @(posedge clk);
        #1;
        chk(8'hFF, 4'd0, "R9 ais during reset");
        @(negedge clk);
        rst_n = 1'b1;
        ais_n = 1'b1;
        #1;
        chk(8'h9B, 4'd0, "R1 reset state");

        // Table walk over the whole multiframe, then wrap.
        for (int f = 0; f < 16; f++) begin
            #0;
            chk(EXP[f], 4'(f), f[0] ? "R4 R5 R6 R7 odd frame" : "R2 R3 even frame");
            step(1'b1, 1'b0);
        end
        chk(EXP[0], 4'd0, "R10 wrap 15->0");

        // Hold without strobe.
        step(1'b0, 1'b0);
        chk(EXP[0], 4'd0, "R10 hold");

        // C bits inverted.
        crc_bits = 4'b1010;
        #1 chk(8'h1B, 4'd0, "R3 C1=0");
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        chk(8'h9B, 4'd2, "R3 C2=1");
        crc_bits = 4'b0101;

        // Alarm off on frame 1.
        go_frame(1);
        rai = 1'b0;
        #1 chk(8'h55, 4'd1, "R4 rai=0");
        rai = 1'b1;

        // Data-link override on Sa4 with 0.
        dl_en = 1'b1; dl_sel = 3'd0; dl_bit = 1'b0;
        #1 chk(8'h65, 4'd1, "R8 override Sa4");
        dl_sel = 3'd5;
        #1 chk(8'h75, 4'd1, "R8 select 5 ignored");
        dl_sel = 3'd2;
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        chk(8'hF8, 4'd5, "R8 override Sa6");
        step(1'b1, 1'b0);
        chk(8'h1B, 4'd6, "R8 even frame untouched");
        dl_en = 1'b0;

        // Multiframe restart with simultaneous strobe.
        go_frame(7);
        chk(EXP[7], 4'd7, "R10 advance to 7");
        step(1'b1, 1'b1);
        chk(EXP[0], 4'd0, "R11 mf_start priority");

        // E bits swapped.
        e_bits = 2'b01;
        go_frame(13);
        chk(8'hE3, 4'd13, "R6 E1=1");
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        chk(8'h72, 4'd15, "R6 E2=0");

        // AIS mid-run.
        ais_n = 1'b0;
        #1 chk(8'hFF, 4'd15, "R9 ais forces ones");
        ais_n = 1'b1;
        #1 chk(8'h72, 4'd15, "R9 ais released");

        // Reset mid-multiframe.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        e_bits = 2'b10;
        #1 chk(EXP[0], 4'd0, "R1 reset mid-run");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule